// File: doc/BRIEF.md
# Multi-interface basic-rate TDM slot multiplexer

This block merges the bearer and signalling channels of several basic-rate ISDN interfaces onto a single 32-slot serial TDM line, and splits a received line back into per-interface channels. Each enabled interface owns three consecutive 8-bit slots: one for each of its two bearer channels and one for its 2-bit signalling channel. The signalling slot is a full byte so that every channel starts on a byte boundary. Its six spare bits are sent as idle ones and are ignored on receive.

The block runs on the line bit clock. A single-cycle frame-sync pulse marks the first bit of the frame, and after that the position counter runs freely, wrapping every 256 bits. Transmit bytes are captured in the sync cycle, so an upstream change during a frame cannot split a slot. Received bytes for all enabled interfaces are released together, with a one-cycle strobe, once the last interface slot of the frame has been assembled. The parameter `NUM_IF` (1 to 10) sets how many interfaces are carried. Every slot beyond them idles on transmit and is discarded on receive.

Top module: `bri_tdm_mux`

## Requirements
- R1: The cycle with `fsync` high is line position 0. Position p is bit p mod 8 of slot p/8, and bits travel most-significant first. `tx_ser` carries the bit for position p in the cycle after position p.
- R2: Interface n sends `tx_b1[8n+7:8n]` in slot 3n, `tx_b2[8n+7:8n]` in slot 3n+1 and `tx_d[2n+1:2n]` in slot 3n+2.
- R3: In a signalling slot, `tx_d[2n+1]` goes out first and `tx_d[2n]` second. The six remaining bit times of that slot are sent as 1.
- R4: Every slot numbered 3*NUM_IF or higher, including slots 30 and 31, is sent as all ones.
- R5: Transmit inputs are captured in the `fsync` cycle. Changes made after that cycle have no effect on `tx_ser` until the next `fsync`.
- R6: Before the first `fsync` after reset, `tx_ser` stays 1 and `rx_valid` stays 0.
- R7: `rx_ser` is sampled in the cycle of each line position. Slot bytes are assembled most-significant first. `rx_d` for interface n takes the first two bits of slot 3n+2. The six masked bits, and all slots from 3*NUM_IF upward, have no effect on any output.
- R8: `rx_valid` is a one-cycle pulse, 241 cycles after the `fsync` cycle (two cycles after the last bit of slot 29). All receive outputs change together in that cycle and hold their values at all other times.
- R9: An `fsync` pulse arriving in the middle of a frame restarts both directions at position 0 and recaptures the transmit inputs.
- R10: Without a further `fsync`, the counter wraps from position 255 to 0. The next frame reuses the previously captured transmit bytes, and `rx_valid` still fires at position 241.
- R11: During and straight after reset, `tx_ser` is 1 and `rx_b1`, `rx_b2`, `rx_d` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | One-cycle pulse marking line position 0 |
| tx_b1 | input | 8*NUM_IF | First bearer byte per interface |
| tx_b2 | input | 8*NUM_IF | Second bearer byte per interface |
| tx_d | input | 2*NUM_IF | Signalling bits per interface |
| tx_ser | output | 1 | Serial transmit line |
| rx_ser | input | 1 | Serial receive line |
| rx_b1 | output | 8*NUM_IF | Received first bearer bytes |
| rx_b2 | output | 8*NUM_IF | Received second bearer bytes |
| rx_d | output | 2*NUM_IF | Received signalling bits |
| rx_valid | output | 1 | One-cycle strobe: new receive frame presented |

## Verification
Each transmitted bit is due one cycle after the bench drives its line position. For every driven cycle, the driver queues the expected bit, and the monitor takes exactly one entry off that queue on each following clock edge, so the two stay in step. For every frame that reaches position 241, the driver also queues an expected receive record stamped with the cycle 241 clocks after its sync cycle. The monitor compares the strobe cycle against that stamp and flags any strobe that comes early, late or without an entry. All outputs are sampled 2 ns after the rising edge, when the registered values have settled.

// File: rtl/bri_tdm_pkg.sv
package bri_tdm_pkg;

   // Slots per interface: first bearer, second bearer, signalling
   localparam int IF_SLOTS = 3;

   typedef enum logic [1:0] {
      CH_B1   = 2'd0,
      CH_B2   = 2'd1,
      CH_SIG  = 2'd2,
      CH_IDLE = 2'd3
   } ch_kind_t;

   // Role of a frame slot for a given number of enabled interfaces
   function automatic ch_kind_t slot_kind(input int slot, input int num_if);
      if (slot >= IF_SLOTS * num_if) return CH_IDLE;
      case (slot % IF_SLOTS)
         0:       return CH_B1;
         1:       return CH_B2;
         default: return CH_SIG;
      endcase
   endfunction

endpackage

// File: rtl/bri_frame_timer.sv
module bri_frame_timer #(
   parameter int FRAME_SLOTS = 32,
   parameter int SLOT_BITS   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fsync,
   output logic                           active,
   output logic [$clog2(FRAME_SLOTS)-1:0] slot,
   output logic [$clog2(SLOT_BITS)-1:0]   bitn
);
   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int SLOT_W = $clog2(FRAME_SLOTS);
   localparam int POS_W  = SLOT_W + BIT_W;

   logic [POS_W-1:0] cnt_q;
   logic [POS_W-1:0] pos;
   logic             synced_q;

   // Sync forces position 0 in its own cycle
   assign pos    = fsync ? '0 : cnt_q;
   assign active = synced_q | fsync;
   assign slot   = pos[POS_W-1:BIT_W];
   assign bitn   = pos[BIT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         synced_q <= 1'b0;
      end else begin
         cnt_q    <= pos + POS_W'(1);      // power-of-two frame wraps freely
         synced_q <= synced_q | fsync;
      end
   end
endmodule

// File: rtl/bri_tx_packer.sv
module bri_tx_packer
   import bri_tdm_pkg::*;
#(
   parameter int NUM_IF      = 10,
   parameter int FRAME_SLOTS = 32,
   parameter int SLOT_BITS   = 8,
   parameter int D_BITS      = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fsync,
   input  logic                           active,
   input  logic [$clog2(FRAME_SLOTS)-1:0] slot,
   input  logic [$clog2(SLOT_BITS)-1:0]   bitn,
   input  logic [NUM_IF*SLOT_BITS-1:0]    tx_b1,
   input  logic [NUM_IF*SLOT_BITS-1:0]    tx_b2,
   input  logic [NUM_IF*D_BITS-1:0]       tx_d,
   output logic                           tx_ser
);
   localparam int BIT_W   = $clog2(SLOT_BITS);
   localparam int PAD_W   = SLOT_BITS - D_BITS;
   localparam logic [BIT_W-1:0] BIT_MSB = BIT_W'(SLOT_BITS - 1);

   logic [NUM_IF*SLOT_BITS-1:0] hold_b1_q, hold_b2_q;
   logic [NUM_IF*D_BITS-1:0]    hold_d_q;
   logic [NUM_IF*SLOT_BITS-1:0] src_b1, src_b2;
   logic [NUM_IF*D_BITS-1:0]    src_d;
   logic [SLOT_BITS-1:0]        slot_byte [FRAME_SLOTS];
   logic [BIT_W-1:0]            sel;

   // In the sync cycle the live inputs feed slot 0, afterwards the captured copy
   assign src_b1 = fsync ? tx_b1 : hold_b1_q;
   assign src_b2 = fsync ? tx_b2 : hold_b2_q;
   assign src_d  = fsync ? tx_d  : hold_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_b1_q <= '0;
         hold_b2_q <= '0;
         hold_d_q  <= '0;
      end else if (fsync) begin
         hold_b1_q <= tx_b1;
         hold_b2_q <= tx_b2;
         hold_d_q  <= tx_d;
      end
   end

   // Fixed slot map, resolved at elaboration
   for (genvar s = 0; s < FRAME_SLOTS; s++) begin : g_slot
      localparam ch_kind_t KIND = slot_kind(s, NUM_IF);
      localparam int       IFN  = s / IF_SLOTS;
      if (KIND == CH_B1) begin : g_b1
         assign slot_byte[s] = src_b1[IFN*SLOT_BITS +: SLOT_BITS];
      end else if (KIND == CH_B2) begin : g_b2
         assign slot_byte[s] = src_b2[IFN*SLOT_BITS +: SLOT_BITS];
      end else if (KIND == CH_SIG) begin : g_sig
         assign slot_byte[s] = {src_d[IFN*D_BITS +: D_BITS], {PAD_W{1'b1}}};
      end else begin : g_idle
         assign slot_byte[s] = '1;
      end
   end

   assign sel = BIT_MSB - bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_ser <= 1'b1;
      else        tx_ser <= active ? slot_byte[slot][sel] : 1'b1;
   end
endmodule

// File: rtl/bri_rx_unpacker.sv
module bri_rx_unpacker
   import bri_tdm_pkg::*;
#(
   parameter int NUM_IF      = 10,
   parameter int FRAME_SLOTS = 32,
   parameter int SLOT_BITS   = 8,
   parameter int D_BITS      = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           active,
   input  logic [$clog2(FRAME_SLOTS)-1:0] slot,
   input  logic [$clog2(SLOT_BITS)-1:0]   bitn,
   input  logic                           rx_ser,
   output logic [NUM_IF*SLOT_BITS-1:0]    rx_b1,
   output logic [NUM_IF*SLOT_BITS-1:0]    rx_b2,
   output logic [NUM_IF*D_BITS-1:0]       rx_d,
   output logic                           rx_valid
);
   localparam int SLOT_W    = $clog2(FRAME_SLOTS);
   localparam int MAX_IF    = FRAME_SLOTS / IF_SLOTS;
   localparam int LAST_SLOT = IF_SLOTS * MAX_IF - 1;

   logic [SLOT_BITS-2:0] shift_q;
   logic [SLOT_BITS-1:0] byte_now;
   logic                 slot_end;
   logic                 done_q;
   logic [SLOT_BITS-1:0] st_b1 [NUM_IF];
   logic [SLOT_BITS-1:0] st_b2 [NUM_IF];
   logic [D_BITS-1:0]    st_d  [NUM_IF];

   assign byte_now = {shift_q, rx_ser};
   assign slot_end = active && (bitn == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (active) begin
         shift_q <= {shift_q[SLOT_BITS-3:0], rx_ser};
      end
   end

   // Per-slot staging: a byte lands here when its last bit arrives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_IF; i++) begin
            st_b1[i] <= '0;
            st_b2[i] <= '0;
            st_d[i]  <= '0;
         end
      end else if (slot_end) begin
         for (int i = 0; i < NUM_IF; i++) begin
            if (slot == SLOT_W'(IF_SLOTS*i))     st_b1[i] <= byte_now;
            if (slot == SLOT_W'(IF_SLOTS*i + 1)) st_b2[i] <= byte_now;
            if (slot == SLOT_W'(IF_SLOTS*i + 2)) st_d[i]  <= byte_now[SLOT_BITS-1 -: D_BITS];
         end
      end
   end

   // Release every interface at once after the last interface slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         rx_valid <= 1'b0;
         rx_b1    <= '0;
         rx_b2    <= '0;
         rx_d     <= '0;
      end else begin
         done_q   <= slot_end && (slot == SLOT_W'(LAST_SLOT));
         rx_valid <= done_q;
         if (done_q) begin
            for (int i = 0; i < NUM_IF; i++) begin
               rx_b1[i*SLOT_BITS +: SLOT_BITS] <= st_b1[i];
               rx_b2[i*SLOT_BITS +: SLOT_BITS] <= st_b2[i];
               rx_d[i*D_BITS +: D_BITS]        <= st_d[i];
            end
         end
      end
   end
endmodule

// File: rtl/bri_tdm_mux.sv
module bri_tdm_mux #(
   parameter int NUM_IF      = 10,
   parameter int FRAME_SLOTS = 32,
   parameter int SLOT_BITS   = 8,
   parameter int D_BITS      = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fsync,
   input  logic [NUM_IF*SLOT_BITS-1:0] tx_b1,
   input  logic [NUM_IF*SLOT_BITS-1:0] tx_b2,
   input  logic [NUM_IF*D_BITS-1:0]    tx_d,
   output logic                        tx_ser,
   input  logic                        rx_ser,
   output logic [NUM_IF*SLOT_BITS-1:0] rx_b1,
   output logic [NUM_IF*SLOT_BITS-1:0] rx_b2,
   output logic [NUM_IF*D_BITS-1:0]    rx_d,
   output logic                        rx_valid
);
   localparam int BIT_W  = $clog2(SLOT_BITS);
   localparam int SLOT_W = $clog2(FRAME_SLOTS);
   localparam int MAX_IF = FRAME_SLOTS / bri_tdm_pkg::IF_SLOTS;

   if (NUM_IF < 1 || NUM_IF > MAX_IF) begin : g_bad_num_if
      $error("NUM_IF must lie between 1 and FRAME_SLOTS/3");
   end
   if ((1 << SLOT_W) != FRAME_SLOTS) begin : g_bad_frame
      $error("FRAME_SLOTS must be a power of two");
   end
   if ((1 << BIT_W) != SLOT_BITS || SLOT_BITS < 4) begin : g_bad_slot
      $error("SLOT_BITS must be a power of two of at least 4");
   end
   if (D_BITS < 1 || D_BITS >= SLOT_BITS) begin : g_bad_dbits
      $error("D_BITS must be at least 1 and below SLOT_BITS");
   end

   logic              active;
   logic [SLOT_W-1:0] slot;
   logic [BIT_W-1:0]  bitn;

   bri_frame_timer #(
      .FRAME_SLOTS (FRAME_SLOTS),
      .SLOT_BITS   (SLOT_BITS)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .fsync  (fsync),
      .active (active),
      .slot   (slot),
      .bitn   (bitn)
   );

   bri_tx_packer #(
      .NUM_IF      (NUM_IF),
      .FRAME_SLOTS (FRAME_SLOTS),
      .SLOT_BITS   (SLOT_BITS),
      .D_BITS      (D_BITS)
   ) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .fsync  (fsync),
      .active (active),
      .slot   (slot),
      .bitn   (bitn),
      .tx_b1  (tx_b1),
      .tx_b2  (tx_b2),
      .tx_d   (tx_d),
      .tx_ser (tx_ser)
   );

   bri_rx_unpacker #(
      .NUM_IF      (NUM_IF),
      .FRAME_SLOTS (FRAME_SLOTS),
      .SLOT_BITS   (SLOT_BITS),
      .D_BITS      (D_BITS)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .slot     (slot),
      .bitn     (bitn),
      .rx_ser   (rx_ser),
      .rx_b1    (rx_b1),
      .rx_b2    (rx_b2),
      .rx_d     (rx_d),
      .rx_valid (rx_valid)
   );
endmodule

// File: rtl/bri_tdm_chk.sv
module bri_tdm_chk #(
   parameter int NUM_IF      = 10,
   parameter int FRAME_SLOTS = 32,
   parameter int SLOT_BITS   = 8,
   parameter int D_BITS      = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fsync,
   input logic                        tx_ser,
   input logic [NUM_IF*SLOT_BITS-1:0] rx_b1,
   input logic [NUM_IF*SLOT_BITS-1:0] rx_b2,
   input logic [NUM_IF*D_BITS-1:0]    rx_d,
   input logic                        rx_valid
);
   localparam int BIT_W    = $clog2(SLOT_BITS);
   localparam int SLOT_W   = $clog2(FRAME_SLOTS);
   localparam int POS_W    = SLOT_W + BIT_W;
   localparam int MAX_IF   = FRAME_SLOTS / 3;
   localparam int LAST_POS = 3 * MAX_IF * SLOT_BITS - 1;

   // Independent position tracking from the sync input
   logic [POS_W-1:0] c_cnt_q, c_pos, shown_q;
   logic             seen_q, shown_act_q, due1_q, due2_q;
   int               shown_slot, shown_bit;

   assign c_pos      = fsync ? '0 : c_cnt_q;
   assign shown_slot = int'(shown_q[POS_W-1:BIT_W]);
   assign shown_bit  = int'(shown_q[BIT_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_cnt_q     <= '0;
         shown_q     <= '0;
         seen_q      <= 1'b0;
         shown_act_q <= 1'b0;
         due1_q      <= 1'b0;
         due2_q      <= 1'b0;
      end else begin
         c_cnt_q     <= c_pos + POS_W'(1);
         shown_q     <= c_pos;
         seen_q      <= seen_q | fsync;
         shown_act_q <= seen_q | fsync;
         due1_q      <= (seen_q | fsync) && (c_pos == POS_W'(LAST_POS));
         due2_q      <= due1_q;
      end
   end

   assert_idle_presync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !shown_act_q |-> tx_ser);

   assert_no_valid_presync_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !rx_valid);

   assert_sig_pad_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (shown_act_q && shown_slot < 3*NUM_IF && (shown_slot % 3) == 2 && shown_bit >= D_BITS)
      |-> tx_ser);

   assert_spare_slot_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shown_act_q && shown_slot >= 3*NUM_IF) |-> tx_ser);

   assert_valid_on_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
      due2_q |-> rx_valid);

   assert_valid_only_when_due_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> due2_q);

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_b1) && $stable(rx_b2) && $stable(rx_d)));
endmodule

bind bri_tdm_mux bri_tdm_chk #(
   .NUM_IF      (NUM_IF),
   .FRAME_SLOTS (FRAME_SLOTS),
   .SLOT_BITS   (SLOT_BITS),
   .D_BITS      (D_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fsync    (fsync),
   .tx_ser   (tx_ser),
   .rx_b1    (rx_b1),
   .rx_b2    (rx_b2),
   .rx_d     (rx_d),
   .rx_valid (rx_valid)
);

// File: tb/sim_bri_tdm_mux.sv
module sim_bri_tdm_mux;
   localparam int N    = 8;
   localparam int SB   = 8;
   localparam int FS   = 32;
   localparam int DB   = 2;
   localparam int FB   = FS * SB;
   localparam int MAXI = FS / 3;
   localparam int DUE  = 3 * MAXI * SB + 1;   // 241 cycles after sync

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fsync = 1'b0;
   logic            rx_ser = 1'b0;
   logic [N*SB-1:0] tx_b1 = '0, tx_b2 = '0;
   logic [N*DB-1:0] tx_d = '0;
   logic            tx_ser, rx_valid;
   logic [N*SB-1:0] rx_b1, rx_b2;
   logic [N*DB-1:0] rx_d;

   always #5 clk = ~clk;

   bri_tdm_mux #(.NUM_IF(N), .FRAME_SLOTS(FS), .SLOT_BITS(SB), .D_BITS(DB)) u0 (
      .clk(clk), .rst_n(rst_n), .fsync(fsync),
      .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_d(tx_d), .tx_ser(tx_ser),
      .rx_ser(rx_ser), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d), .rx_valid(rx_valid)
   );

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   typedef struct { logic bitv; string tag; } tx_item_t;
   typedef struct { logic [N*SB-1:0] b1, b2; logic [N*DB-1:0] d; int due; } rx_item_t;
   tx_item_t txq[$];
   rx_item_t rxq[$];

   logic [N*SB-1:0] lat_b1 = '0, lat_b2 = '0;
   logic [N*DB-1:0] lat_d = '0;
   logic [7:0] rb1 [MAXI];
   logic [7:0] rb2 [MAXI];
   logic [1:0] rd  [MAXI];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Expected transmit bit for line position p from the captured bytes (R1, R2, R3, R4)
   function automatic logic exp_tx(input int p);
      int slot = p / SB, b = p % SB, i = slot / 3;
      if (slot >= 3*N) return 1'b1;
      case (slot % 3)
         0:       return lat_b1[i*SB + (SB-1-b)];
         1:       return lat_b2[i*SB + (SB-1-b)];
         default: return (b < DB) ? lat_d[i*DB + (DB-1-b)] : 1'b1;
      endcase
   endfunction

   function automatic string tx_tag(input int p);
      int slot = p / SB, b = p % SB;
      if (slot >= 3*N) return "R4";
      if (slot % 3 == 2) return (b < DB) ? "R3" : "R3 pad";
      return "R1/R2";
   endfunction

   // Receive line content; masked bits and spare slots carry junk (R7)
   function automatic logic rx_bit(input int p);
      int slot = p / SB, b = p % SB, i = slot / 3;
      if (slot >= 3*MAXI) return logic'(p % 3 == 0);
      case (slot % 3)
         0:       return rb1[i][SB-1-b];
         1:       return rb2[i][SB-1-b];
         default: return (b < DB) ? rd[i][DB-1-b] : logic'((p >> 1) & 1);
      endcase
   endfunction

   task automatic set_rx(input int seed);
      for (int i = 0; i < MAXI; i++) begin
         rb1[i] = 8'(seed*37 + i*11 + 5);
         rb2[i] = 8'((seed*91) ^ (i*23));
         rd[i]  = 2'(seed + i);
      end
   endtask

   task automatic set_tx(input int seed);
      for (int i = 0; i < N; i++) begin
         tx_b1[i*SB +: SB] = 8'(seed*13 + i*29 + 1);
         tx_b2[i*SB +: SB] = 8'((seed*7) ^ (i*51));
         tx_d[i*DB +: DB]  = 2'(seed + i*3);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         fsync  = 1'b0;
         rx_ser = logic'(k % 2);
         txq.push_back('{1'b1, "R6"});
      end
   endtask

   task automatic run_frame(input bit with_fs, input int nbits, input string tag, input bit change_mid);
      for (int p = 0; p < nbits; p++) begin
         @(negedge clk);
         fsync = with_fs && (p == 0);
         if (with_fs && p == 0) begin
            lat_b1 = tx_b1; lat_b2 = tx_b2; lat_d = tx_d;
         end
         if (change_mid && p == 3) begin      // R5: edit inputs after capture
            tx_b1 = ~tx_b1;
            tx_b2 = tx_b2 ^ {N{8'h5A}};
            tx_d  = ~tx_d;
         end
         rx_ser = rx_bit(p);
         txq.push_back('{exp_tx(p), (tag == "") ? tx_tag(p) : tag});
         if (p == 0 && nbits >= DUE) begin
            rx_item_t r;
            for (int i = 0; i < N; i++) begin
               r.b1[i*SB +: SB] = rb1[i];
               r.b2[i*SB +: SB] = rb2[i];
               r.d[i*DB +: DB]  = rd[i];
            end
            r.due = cyc + DUE;
            rxq.push_back(r);
         end
      end
   endtask

   // Monitor: one transmit entry per edge, receive records on strobe
   initial begin
      tx_item_t it;
      rx_item_t r;
      forever begin
         @(posedge clk);
         #2;
         if (!rst_n) continue;
         if (txq.size() > 0) begin
            it = txq.pop_front();
            check(tx_ser === it.bitv, it.tag, "tx_ser bit", 64'(tx_ser), 64'(it.bitv));
         end
         if (rx_valid) begin
            if (rxq.size() == 0) begin
               check(1'b0, "R8", "unexpected rx_valid", 64'd1, 64'd0);
            end else begin
               r = rxq.pop_front();
               check(cyc == r.due, "R8", "rx_valid cycle", 64'(cyc), 64'(r.due));
               check(rx_b1 === r.b1, "R7", "rx_b1", rx_b1, r.b1);
               check(rx_b2 === r.b2, "R7", "rx_b2", rx_b2, r.b2);
               check(rx_d === r.d, "R7", "rx_d", 64'(rx_d), 64'(r.d));
            end
         end else if (rxq.size() > 0 && cyc >= rxq[0].due) begin
            check(1'b0, "R8", "missing rx_valid", 64'(cyc), 64'(rxq[0].due));
            void'(rxq.pop_front());
         end
      end
   end

   initial begin
      set_rx(0);
      repeat (4) @(negedge clk);
      // R11: values while and right after reset
      check(tx_ser === 1'b1, "R11", "tx_ser in reset", 64'(tx_ser), 64'd1);
      check(rx_valid === 1'b0, "R11", "rx_valid in reset", 64'(rx_valid), 64'd0);
      check(rx_b1 === '0 && rx_b2 === '0, "R11", "rx bytes in reset", rx_b1 | rx_b2, 64'd0);
      check(rx_d === '0, "R11", "rx_d in reset", 64'(rx_d), 64'd0);
      rst_n = 1'b1;

      idle(20);                                // R6: no sync yet

      set_tx(1); set_rx(1);
      run_frame(1'b1, FB, "", 1'b0);           // R1 R2 R3 R4 R7 R8 base frame

      set_tx(2); set_rx(2);
      run_frame(1'b1, FB, "R5", 1'b1);         // R5: mid-frame input change

      set_tx(3); set_rx(3);
      run_frame(1'b0, FB, "R10", 1'b0);        // R10: free-run wrap keeps old bytes

      set_tx(4); set_rx(4);
      run_frame(1'b1, 100, "", 1'b0);          // truncated frame

      set_tx(5); set_rx(5);
      run_frame(1'b1, FB, "R9", 1'b0);         // R9: resync mid-frame

      tx_b1 = '0; tx_b2 = '1; tx_d = '0;       // corner: pad ones beside zero signalling
      set_rx(6);
      for (int i = 0; i < MAXI; i++) begin rb1[i] = 8'hFF; rb2[i] = 8'h00; rd[i] = 2'b10; end
      run_frame(1'b1, FB, "", 1'b0);

      repeat (3) @(negedge clk);
      check(rxq.size() == 0, "R8", "pending rx records", 64'(rxq.size()), 64'd0);
      check(txq.size() == 0, "R1", "pending tx bits", 64'(txq.size()), 64'd0);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule